// File: doc/BRIEF.md
# Flash Converter Digital Back-End

This block is the digital half of a 6-bit parallel (flash) analog-to-digital converter. It receives the 64 comparator decisions as an ideal thermometer vector and turns them into a 6-bit binary code plus an overflow flag. The comparators below the top quantize the code range. The topmost comparator only reports that the input has gone above full scale.

Conversion is a two-stage pipeline on one clock whose halves are assigned by a phase-select input. The comparator vector is frozen at the edge that closes the sample half. The frozen vector is decoded, and the result is loaded into an output register at the edge that opens the next sample half. A result therefore appears one conversion after its sample.

Two enables model the output drivers. One enable releases only the six code bits. The other releases all seven outputs, so that two converters can share a bus when cascaded or interleaved.

Top module: `flash_backend`

## Requirements
- R1: When the top comparator (`thermIn[63]`) is set in a captured vector, `ovfOut` is 1 and `codeOut` is 0 for that conversion. Otherwise `ovfOut` is 0.
- R2: For a clean thermometer in which `thermIn[k-1:0]` are ones and `thermIn[62:k]` are zeros, `codeOut` equals k, for k from 0 to 63.
- R3: A lone cleared bit inside a run of ones does not change the result. The code is one plus the index of the highest bit in `thermIn[62:0]` that is set while the bit above it is clear; bit 62 counts as such a bit whenever it is set.
- R4: With `phaseSel` = 0, the vector is captured at the rising edge of `clk`, and the output register updates at the following falling edge.
- R5: With `phaseSel` = 1, the vector is captured at the falling edge of `clk`, and the output register updates at the following rising edge.
- R6: Once updated, the outputs hold their value through the next capture edge until the next update edge. Input changes between capture edges have no effect.
- R7: With `outEnable` = 1 and `dataRelease` = 0, both `codeOe` and `ovfOe` are 1.
- R8: With `outEnable` = 1 and `dataRelease` = 1, `codeOe` is 0 and `ovfOe` is 1.
- R9: With `outEnable` = 0, `codeOe` and `ovfOe` are both 0, whatever `dataRelease` is.
- R10: While `rst` is high, the capture and output stages clear on their clock edges, so `codeOut` is 0 and `ovfOut` is 0 whatever `thermIn` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| phaseSel | input | 1 | 0: sample during clock low; 1: sample during clock high |
| thermIn | input | 64 | Comparator decisions; bit i is comparator i+1, bit 63 is the overflow comparator |
| dataRelease | input | 1 | 1 releases the six code bits |
| outEnable | input | 1 | 0 releases all seven outputs |
| codeOut | output | 6 | Registered binary code |
| ovfOut | output | 1 | Registered overflow flag |
| codeOe | output | 1 | Driver enable for `codeOut` |
| ovfOe | output | 1 | Driver enable for `ovfOut` |

## Verification
The bench goes after several corner cases. It checks the code extremes 0 and 63 next to an overflow vector: a decoder that counted bit 63 as a code bit would show 0 or wrap instead of setting the flag. It also sends a vector with one bubble: a plain ones count would come out one low. Each result is checked at the update edge for both phase settings, and checked again just after the next capture edge. A design that registered on the wrong edge, or that let the newer input show through too early, would be off by one conversion or change in the middle of a result. All four enable combinations are driven, which catches a swapped or inverted enable. A reset applied in mid-stream must clear a nonzero output.

// File: rtl/flash_backend_pkg.sv
`timescale 1ns/1ps
package flash_backend_pkg;
  localparam int CODE_BITS = 6;
  localparam int NUM_COMP  = 2 ** CODE_BITS;

  typedef struct packed {
    logic codeOe;
    logic ovfOe;
  } drvStrobes_t;
endpackage

// File: rtl/thermo_decoder.sv
`timescale 1ns/1ps
module thermo_decoder #(
  parameter int CODE_W = 6,
  localparam int NCMP = 2 ** CODE_W
) (
  input  logic [NCMP-1:0]   therm,
  output logic [CODE_W-1:0] code,
  output logic              ovf
);
  // edgeBit[k]: comparator k+1 set and the one above it clear
  logic [NCMP-2:0] edgeBit;

  genvar k;
  generate
    for (k = 0; k < NCMP - 1; k++) begin : g_edge
      if (k == NCMP - 2) begin : g_top
        assign edgeBit[k] = therm[k];
      end else begin : g_mid
        assign edgeBit[k] = therm[k] & ~therm[k+1];
      end
    end
  endgenerate

  always_comb begin
    code = '0;
    for (int i = 0; i < NCMP - 1; i++) begin
      if (edgeBit[i]) code = CODE_W'(i + 1);
    end
    ovf = therm[NCMP-1];
    if (ovf) code = '0;
  end
endmodule

// File: rtl/flash_ctrl.sv
`timescale 1ns/1ps
module flash_ctrl
  import flash_backend_pkg::*;
(
  input  logic        clk,
  input  logic        phaseSel,
  input  logic        dataRelease,
  input  logic        outEnable,
  output logic        convClk,
  output drvStrobes_t strobes
);
  // convClk is high during the sample half; it falls at capture, rises at update
  assign convClk = clk ^ ~phaseSel;

  always_comb begin
    strobes.ovfOe  = outEnable;
    strobes.codeOe = outEnable & ~dataRelease;
  end

  always_comb begin
    if (outEnable === 1'b1 && dataRelease === 1'b0)
      AST_BOTH_DRIVEN: assert (strobes.codeOe && strobes.ovfOe); // R7
    if (outEnable === 1'b1 && dataRelease === 1'b1)
      AST_CODE_ONLY_RELEASED: assert (!strobes.codeOe && strobes.ovfOe); // R8
    if (outEnable === 1'b0)
      AST_ALL_RELEASED: assert (!strobes.codeOe && !strobes.ovfOe); // R9
  end
endmodule

// File: rtl/flash_datapath.sv
`timescale 1ns/1ps
module flash_datapath #(
  parameter int CODE_W = 6,
  localparam int NCMP = 2 ** CODE_W
) (
  input  logic              convClk,
  input  logic              rst,
  input  logic [NCMP-1:0]   thermIn,
  output logic [CODE_W-1:0] codeQ,
  output logic              ovfQ
);
  logic [NCMP-1:0]   thermLatch;
  logic [CODE_W-1:0] decCode;
  logic              decOvf;
  logic [NCMP-2:0]   lowInc;

  // capture stage: closes the sample half
  always_ff @(negedge convClk) begin
    if (rst) thermLatch <= '0;
    else     thermLatch <= thermIn;
  end

  thermo_decoder #(.CODE_W(CODE_W)) u_dec (
    .therm (thermLatch),
    .code  (decCode),
    .ovf   (decOvf)
  );

  // output stage: opens the next sample half
  always_ff @(posedge convClk) begin
    if (rst) begin
      codeQ <= '0;
      ovfQ  <= 1'b0;
    end else begin
      codeQ <= decCode;
      ovfQ  <= decOvf;
    end
  end

  assign lowInc = thermLatch[NCMP-2:0] + {{(NCMP-2){1'b0}}, 1'b1};

  always_ff @(posedge convClk) begin
    if (!rst && !thermLatch[NCMP-1] && ((lowInc & thermLatch[NCMP-2:0]) == '0))
      AST_CLEAN_COUNT: assert (decCode == CODE_W'($countones(thermLatch[NCMP-2:0]))); // R2
  end

  AST_OVF_CLEARS_CODE: assert property (@(posedge convClk) disable iff (rst)
    ovfQ |-> codeQ == '0); // R1
  AST_OVF_FROM_TOP: assert property (@(posedge convClk) disable iff (rst)
    ovfQ == $past(thermLatch[NCMP-1])); // R1
  AST_RESET_CLEARS: assert property (@(posedge convClk)
    rst |=> (codeQ == '0 && !ovfQ)); // R10
endmodule

// File: rtl/flash_backend.sv
`timescale 1ns/1ps
module flash_backend
  import flash_backend_pkg::*;
#(
  parameter int CODE_W = CODE_BITS,
  localparam int NCMP = 2 ** CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phaseSel,
  input  logic [NCMP-1:0]   thermIn,
  input  logic              dataRelease,
  input  logic              outEnable,
  output logic [CODE_W-1:0] codeOut,
  output logic              ovfOut,
  output logic              codeOe,
  output logic              ovfOe
);
  logic        convClk;
  drvStrobes_t strobes;

  flash_ctrl u_ctrl (
    .clk         (clk),
    .phaseSel    (phaseSel),
    .dataRelease (dataRelease),
    .outEnable   (outEnable),
    .convClk     (convClk),
    .strobes     (strobes)
  );

  flash_datapath #(.CODE_W(CODE_W)) u_dp (
    .convClk (convClk),
    .rst     (rst),
    .thermIn (thermIn),
    .codeQ   (codeOut),
    .ovfQ    (ovfOut)
  );

  assign codeOe = strobes.codeOe;
  assign ovfOe  = strobes.ovfOe;
endmodule

// File: tb/flash_backend_tb.sv
`timescale 1ns/1ps
module flash_backend_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        phaseSel = 1'b0;
  logic [63:0] thermIn = '0;
  logic        dataRelease = 1'b0;
  logic        outEnable = 1'b1;
  logic [5:0]  codeOut;
  logic        ovfOut;
  logic        codeOe;
  logic        ovfOe;

  int checks = 0;
  int errors = 0;
  int regCnt = 0;
  bit monOn = 1'b0;

  logic [6:0] expQ[$];
  int         dueQ[$];
  string      tagQ[$];

  always #10 clk = ~clk;

  flash_backend u_dut (
    .clk(clk), .rst(rst), .phaseSel(phaseSel), .thermIn(thermIn),
    .dataRelease(dataRelease), .outEnable(outEnable),
    .codeOut(codeOut), .ovfOut(ovfOut), .codeOe(codeOe), .ovfOe(ovfOe)
  );

  function automatic logic [63:0] therm(input int k);
    if (k >= 64) return '1;
    return (64'd1 << k) - 64'd1;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitReg();
    if (phaseSel) @(posedge clk); else @(negedge clk);
  endtask

  task automatic waitCap();
    if (phaseSel) @(negedge clk); else @(posedge clk);
  endtask

  // driver: apply one vector just after an update edge, push its expected result
  task automatic drive(input logic [63:0] vec, input int expCode, input bit expOvf, input string tag);
    waitReg();
    #2;
    thermIn = vec;
    expQ.push_back({expOvf, 6'(expCode)});
    dueQ.push_back(regCnt + 1);
    tagQ.push_back(tag);
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  // monitor: compare at each update edge, then check the hold after the capture edge
  initial begin
    forever begin
      waitReg();
      regCnt++;
      #5;
      if (monOn && expQ.size() != 0 && dueQ[0] == regCnt) begin
        logic [6:0] e;
        string t;
        e = expQ.pop_front();
        void'(dueQ.pop_front());
        t = tagQ.pop_front();
        check({t, " code"}, 32'(codeOut), 32'(e[5:0]));
        check({t, " ovf"}, 32'(ovfOut), 32'(e[6]));
        waitCap();
        #3;
        check("R6 hold after capture edge", 32'({ovfOut, codeOut}), 32'(e));
      end
    end
  end

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #3_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [63:0] v;
    // R10: reset clears even with every comparator set
    thermIn = '1;
    repeat (4) @(posedge clk);
    #3;
    check("R10 reset code", 32'(codeOut), 32'd0);
    check("R10 reset ovf", 32'(ovfOut), 32'd0);
    thermIn = '0;
    @(negedge clk);
    #2;
    rst = 1'b0;
    monOn = 1'b1;

    // phase 0 stream
    drive(therm(0), 0, 1'b0, "R2 R4 zero");
    drive(therm(1), 1, 1'b0, "R2 R4 one");
    drive(therm(5), 5, 1'b0, "R2 R4 five");
    drive(therm(31), 31, 1'b0, "R2 R4 mid-1");
    drive(therm(32), 32, 1'b0, "R2 R4 mid");
    drive(therm(63), 63, 1'b0, "R2 R4 full");
    drive(therm(64), 0, 1'b1, "R1 R4 overflow");
    v = therm(40); v[20] = 1'b0;
    drive(v, 40, 1'b0, "R3 R4 bubble");
    v = therm(64); v[10] = 1'b0;
    drive(v, 0, 1'b1, "R1 R4 overflow with bubble");
    drive(therm(17), 17, 1'b0, "R2 R4 seventeen");
    drain();

    // driver enables
    outEnable = 1'b1; dataRelease = 1'b0; #1;
    check("R7 codeOe", 32'(codeOe), 32'd1);
    check("R7 ovfOe", 32'(ovfOe), 32'd1);
    dataRelease = 1'b1; #1;
    check("R8 codeOe", 32'(codeOe), 32'd0);
    check("R8 ovfOe", 32'(ovfOe), 32'd1);
    check("R8 ovf value kept", 32'(ovfOut), 32'd0);
    outEnable = 1'b0; #1;
    check("R9 codeOe dr=1", 32'(codeOe), 32'd0);
    check("R9 ovfOe dr=1", 32'(ovfOe), 32'd0);
    dataRelease = 1'b0; #1;
    check("R9 codeOe dr=0", 32'(codeOe), 32'd0);
    check("R9 ovfOe dr=0", 32'(ovfOe), 32'd0);
    outEnable = 1'b1;

    // R10 mid-stream reset with nonzero output, then switch phase
    monOn = 1'b0;
    check("R10 pre-reset nonzero", 32'(codeOut), 32'd17);
    rst = 1'b1;
    thermIn = therm(50);
    repeat (3) @(posedge clk);
    phaseSel = 1'b1;
    repeat (3) @(posedge clk);
    #3;
    check("R10 mid reset code", 32'(codeOut), 32'd0);
    check("R10 mid reset ovf", 32'(ovfOut), 32'd0);
    thermIn = '0;
    @(posedge clk);
    #2;
    rst = 1'b0;
    monOn = 1'b1;

    // phase 1 stream
    drive(therm(63), 63, 1'b0, "R2 R5 full");
    drive(therm(2), 2, 1'b0, "R2 R5 two");
    drive(therm(64), 0, 1'b1, "R1 R5 overflow");
    drive(therm(0), 0, 1'b0, "R2 R5 zero");
    v = therm(9); v[3] = 1'b0;
    drive(v, 9, 1'b0, "R3 R5 bubble");
    drive(therm(48), 48, 1'b0, "R2 R5 forty-eight");
    drain();
    finishRun();
  end
endmodule